// File: doc/BRIEF.md
# Bus Arbiter with Repeat-Run Limits

This block picks one bus master per cycle from a small set of requesters and issues a single-cycle address grant to the winner. Grants stop while the count of address tenures still waiting for their data equals a programmable depth. A data-completion pulse frees one slot. When no run is in progress, requesters are served in round-robin order, starting with the master after the one granted last.

A master that asserts its repeat-request line can keep the bus for a bounded run of back-to-back transactions. The master at index `PCI_IDX` has its own run limit, and every other master shares a second limit. A disable bit takes the CPU master (index `CPU_IDX`) out of arbitration. That bit is loaded from a strap input at reset and can be rewritten by software afterwards.

One configuration register holds the disable bit, the depth code and both repeat codes. It is written in a single cycle and read back combinationally.

Top module: `busArbiter`

## Requirements
- R1: At most one bit of `grant` is high in any cycle. A decision is made at each rising clock edge from the inputs present at that edge. The resulting grant is high for exactly the one following cycle, and only for a master whose `req` was high at that edge.
- R2: While the CPU-disable bit (register bit 0, 1 = disabled) is set, master `CPU_IDX` is never granted. Arbitration among the other requesters continues.
- R3: On reset, register bit 0 takes the value of `cpuDisStrap`. Software can later write it to 0, and the CPU master then becomes eligible from the next decision.
- R4: The depth code sits in register bits [6:4]. Codes 0 to 3 allow 1 to 4 outstanding tenures. No grant is issued at a decision where the outstanding count equals that depth.
- R5: A depth code with bit 2 set (4 to 7) behaves as a depth of one outstanding tenure.
- R6: Each grant adds one to the outstanding count. Each `dataDone` pulse seen while the count is non-zero removes one. A slot freed by `dataDone` at an edge can be used at the next decision after it.
- R7: With no repeat run in progress, the first requesting, eligible master after the last granted one (in ascending index order, wrapping) wins. Out of reset, the search starts at index 0.
- R8: The repeat code for masters other than `PCI_IDX` sits in bits [14:12]. Its limit is code+1. Suppose the last granted master is not `PCI_IDX`, still requests, holds `rptReq`, and has had fewer consecutive run grants than the limit. Then it wins the next decision. When the limit is reached, it goes back to round-robin.
- R9: The repeat code for master `PCI_IDX` sits in bits [10:8], with the same code+1 limit, and is applied independently of bits [14:12].
- R10: A repeat code of 0 gives a limit of one, so `rptReq` has no effect on the order of grants.
- R11: `cfgRdData` returns the stored fields at bit 0, [6:4], [10:8] and [14:12], and 0 in every other bit. Both repeat codes and the depth code reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| cpuDisStrap | input | 1 | Reset value of the CPU-disable bit |
| cfgWrEn | input | 1 | Writes `cfgWrData` into the configuration register |
| cfgWrData | input | 32 | Configuration write value |
| cfgRdData | output | 32 | Configuration read-back |
| req | input | NUM_MASTERS | Bus request, one per master |
| rptReq | input | NUM_MASTERS | Repeat request, one per master |
| dataDone | input | 1 | One pulse per completed data tenure |
| grant | output | NUM_MASTERS | One-cycle address grant, one-hot or zero |

## Verification
Round-robin is tried with all four masters requesting and with a sparse pattern of two, which separates a correct rotation from a fixed priority. Repeat runs are driven with two competing masters under three code settings: separate limits, shared limit and zero. The exact grant sequence shows whether the run length follows the PCI code, the shared code, or neither. Depth is tested by holding one requester with `dataDone` low under a legal code and then under a reserved code. Each stall shows where the limit lies, and a single completion pulse shows the one-cycle delay before the freed slot is used. The CPU-disable bit is checked with the CPU as the only requester and again with every master requesting.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int REG_W       = 32;
  localparam int FIELD_W     = 3;
  localparam int ARB_IDX_W   = 3;
  localparam int CNT_W       = 3;
  localparam int LIM_W       = 4;
  localparam int CPU_DIS_BIT = 0;
  localparam int DEPTH_LSB   = 4;
  localparam int PCI_RPT_LSB = 8;
  localparam int OTH_RPT_LSB = 12;

  localparam logic [REG_W-1:0] WR_MASK =
      (REG_W'(1) << CPU_DIS_BIT) |
      (REG_W'(7) << DEPTH_LSB) |
      (REG_W'(7) << PCI_RPT_LSB) |
      (REG_W'(7) << OTH_RPT_LSB);

  // Strobes from the decision logic to the state-holding datapath.
  typedef struct packed {
    logic                 issue;
    logic                 hold;
    logic [ARB_IDX_W-1:0] idx;
  } arbStrobeT;

  function automatic logic [LIM_W-1:0] rptLimit(input logic [FIELD_W-1:0] code);
    return LIM_W'(code) + LIM_W'(1);
  endfunction

  function automatic logic [CNT_W-1:0] depthLimit(input logic [FIELD_W-1:0] code);
    return code[FIELD_W-1] ? CNT_W'(1) : CNT_W'(code) + CNT_W'(1);
  endfunction
endpackage

// File: rtl/arbCtrl.sv
module arbCtrl
  import arb_pkg::*;
#(
  parameter int NUM_MASTERS = 4,
  parameter int CPU_IDX     = 0,
  parameter int PCI_IDX     = 1
) (
  input  logic [NUM_MASTERS-1:0] req,
  input  logic [NUM_MASTERS-1:0] rptReq,
  input  logic                   cpuDis,
  input  logic [CNT_W-1:0]       depthLim,
  input  logic [CNT_W-1:0]       outCnt,
  input  logic [ARB_IDX_W-1:0]   lastIdx,
  input  logic [LIM_W-1:0]       runCnt,
  input  logic [LIM_W-1:0]       pciLim,
  input  logic [LIM_W-1:0]       othLim,
  output arbStrobeT              strobe
);
  logic [NUM_MASTERS-1:0] elig;
  logic                   room, lastElig, lastRpt, hold, found;
  logic [LIM_W-1:0]       curLim;
  logic [ARB_IDX_W-1:0]   pick;

  always_comb begin
    elig = req;
    if (cpuDis) elig[CPU_IDX] = 1'b0;
    room   = outCnt < depthLim;
    curLim = (lastIdx == ARB_IDX_W'(PCI_IDX)) ? pciLim : othLim;

    lastElig = 1'b0;
    lastRpt  = 1'b0;
    for (int i = 0; i < NUM_MASTERS; i++) begin
      if (ARB_IDX_W'(i) == lastIdx) begin
        lastElig = elig[i];
        lastRpt  = rptReq[i];
      end
    end
    hold = room && lastElig && lastRpt && (runCnt != '0) && (runCnt < curLim);

    // Round-robin search, starting one past the last winner.
    found = 1'b0;
    pick  = '0;
    for (int k = 1; k <= NUM_MASTERS; k++) begin : rrSearch
      int cand;
      cand = int'(lastIdx) + k;
      if (cand >= NUM_MASTERS) cand = cand - NUM_MASTERS;
      for (int j = 0; j < NUM_MASTERS; j++) begin
        if (!found && (j == cand) && elig[j]) begin
          found = 1'b1;
          pick  = ARB_IDX_W'(j);
        end
      end
    end

    strobe.issue = room && (hold || found);
    strobe.hold  = hold;
    strobe.idx   = hold ? lastIdx : pick;
  end
endmodule

// File: rtl/arbDatapath.sv
module arbDatapath
  import arb_pkg::*;
#(
  parameter int NUM_MASTERS = 4,
  parameter int PCI_IDX     = 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cpuDisStrap,
  input  logic                   cfgWrEn,
  input  logic [REG_W-1:0]       cfgWrData,
  input  arbStrobeT              strobe,
  input  logic                   dataDone,
  output logic [REG_W-1:0]       cfgRdData,
  output logic                   cpuDis,
  output logic [CNT_W-1:0]       depthLim,
  output logic [LIM_W-1:0]       pciLim,
  output logic [LIM_W-1:0]       othLim,
  output logic [CNT_W-1:0]       outCnt,
  output logic [ARB_IDX_W-1:0]   lastIdx,
  output logic [LIM_W-1:0]       runCnt,
  output logic [NUM_MASTERS-1:0] grant
);
  logic [REG_W-1:0]       cfgQ;
  logic [NUM_MASTERS-1:0] oneHot;
  logic                   doneOk;

  assign cfgRdData = cfgQ;
  assign cpuDis    = cfgQ[CPU_DIS_BIT];
  assign depthLim  = depthLimit(cfgQ[DEPTH_LSB +: FIELD_W]);
  assign pciLim    = rptLimit(cfgQ[PCI_RPT_LSB +: FIELD_W]);
  assign othLim    = rptLimit(cfgQ[OTH_RPT_LSB +: FIELD_W]);
  assign doneOk    = dataDone && (outCnt != '0);

  always_comb begin
    oneHot = '0;
    for (int i = 0; i < NUM_MASTERS; i++)
      if (ARB_IDX_W'(i) == strobe.idx) oneHot[i] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ <= REG_W'(cpuDisStrap) << CPU_DIS_BIT;
    end else if (cfgWrEn) begin
      cfgQ <= cfgWrData & WR_MASK;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outCnt  <= '0;
      lastIdx <= ARB_IDX_W'(NUM_MASTERS - 1);
      runCnt  <= '0;
      grant   <= '0;
    end else begin
      case ({strobe.issue, doneOk})
        2'b10:   outCnt <= outCnt + CNT_W'(1);
        2'b01:   outCnt <= outCnt - CNT_W'(1);
        default: outCnt <= outCnt;
      endcase
      grant <= strobe.issue ? oneHot : '0;
      if (strobe.issue) begin
        lastIdx <= strobe.idx;
        runCnt  <= strobe.hold ? runCnt + LIM_W'(1) : LIM_W'(1);
      end
    end
  end
endmodule

// File: rtl/busArbiter.sv
module busArbiter
  import arb_pkg::*;
#(
  parameter int NUM_MASTERS = 4,
  parameter int CPU_IDX     = 0,
  parameter int PCI_IDX     = 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cpuDisStrap,
  input  logic                   cfgWrEn,
  input  logic [REG_W-1:0]       cfgWrData,
  output logic [REG_W-1:0]       cfgRdData,
  input  logic [NUM_MASTERS-1:0] req,
  input  logic [NUM_MASTERS-1:0] rptReq,
  input  logic                   dataDone,
  output logic [NUM_MASTERS-1:0] grant
);
  arbStrobeT            strobe;
  logic                 cpuDis;
  logic [CNT_W-1:0]     depthLim, outCnt;
  logic [LIM_W-1:0]     pciLim, othLim, runCnt;
  logic [ARB_IDX_W-1:0] lastIdx;

  arbCtrl #(.NUM_MASTERS(NUM_MASTERS), .CPU_IDX(CPU_IDX), .PCI_IDX(PCI_IDX)) u_ctrl (
    .req(req), .rptReq(rptReq), .cpuDis(cpuDis), .depthLim(depthLim),
    .outCnt(outCnt), .lastIdx(lastIdx), .runCnt(runCnt),
    .pciLim(pciLim), .othLim(othLim), .strobe(strobe)
  );

  arbDatapath #(.NUM_MASTERS(NUM_MASTERS), .PCI_IDX(PCI_IDX)) u_dp (
    .clk(clk), .rstN(rstN), .cpuDisStrap(cpuDisStrap), .cfgWrEn(cfgWrEn),
    .cfgWrData(cfgWrData), .strobe(strobe), .dataDone(dataDone),
    .cfgRdData(cfgRdData), .cpuDis(cpuDis), .depthLim(depthLim),
    .pciLim(pciLim), .othLim(othLim), .outCnt(outCnt), .lastIdx(lastIdx),
    .runCnt(runCnt), .grant(grant)
  );
endmodule

// File: rtl/arbChecker.sv
module arbChecker
  import arb_pkg::*;
#(
  parameter int NUM_MASTERS = 4,
  parameter int CPU_IDX     = 0
) (
  input logic                   clk,
  input logic                   rstN,
  input logic [NUM_MASTERS-1:0] req,
  input logic [NUM_MASTERS-1:0] grant,
  input logic                   dataDone,
  input logic                   cpuDisRd,
  input logic [FIELD_W-1:0]     depthRd
);
  // Independent count of tenures granted earlier and not yet completed.
  logic [CNT_W:0]   pend;
  logic [CNT_W-1:0] depLim;
  logic             anyGrant;

  assign anyGrant = |grant;
  assign depLim   = depthLimit(depthRd);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pend <= '0;
    else pend <= pend + (CNT_W+1)'(anyGrant)
               - (CNT_W+1)'(dataDone && ((pend + (CNT_W+1)'(anyGrant)) != '0));
  end

  assert_one_grant_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grant));

  assert_grant_has_req_R1: assert property (@(posedge clk) disable iff (!rstN)
    anyGrant |-> ((grant & ~$past(req)) == '0));

  assert_cpu_blocked_R2: assert property (@(posedge clk) disable iff (!rstN)
    grant[CPU_IDX] |-> !$past(cpuDisRd));

  assert_depth_cap_R4: assert property (@(posedge clk) disable iff (!rstN)
    anyGrant |-> (pend < (CNT_W+1)'($past(depLim))));
endmodule

bind busArbiter arbChecker #(.NUM_MASTERS(NUM_MASTERS), .CPU_IDX(CPU_IDX)) u_chk (
  .clk(clk), .rstN(rstN), .req(req), .grant(grant), .dataDone(dataDone),
  .cpuDisRd(cfgRdData[arb_pkg::CPU_DIS_BIT]),
  .depthRd(cfgRdData[arb_pkg::DEPTH_LSB +: arb_pkg::FIELD_W])
);

// File: tb/tb_busArbiter.sv
module tb_busArbiter;
  localparam int CLK_PERIOD = 10;
  localparam int NM = 4;

  logic          clk = 1'b0;
  logic          rstN, cpuDisStrap, cfgWrEn, dataDone;
  logic [31:0]   cfgWrData, cfgRdData;
  logic [NM-1:0] req, rptReq, grant;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  busArbiter #(.NUM_MASTERS(NM), .CPU_IDX(0), .PCI_IDX(1)) dut (
    .clk(clk), .rstN(rstN), .cpuDisStrap(cpuDisStrap), .cfgWrEn(cfgWrEn),
    .cfgWrData(cfgWrData), .cfgRdData(cfgRdData), .req(req), .rptReq(rptReq),
    .dataDone(dataDone), .grant(grant)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wrCfg(input logic [31:0] v);
    cfgWrEn = 1'b1; cfgWrData = v;
    tick();
    cfgWrEn = 1'b0;
  endtask

  task automatic expectSeq(input logic [NM-1:0] seq [], input string tag);
    foreach (seq[i]) begin
      tick();
      chk(32'(grant), 32'(seq[i]), tag);
    end
  endtask

  task automatic testReset();
    chk(32'(grant), 32'h0, "R1 reset grant");
    chk(cfgRdData, 32'h1, "R3 R11 reset register");
  endtask

  task automatic testRegs();
    wrCfg(32'hFFFF_FFFF);
    chk(cfgRdData, 32'h0000_7771, "R11 reserved bits zero");
    wrCfg(32'h0000_0001);
    chk(cfgRdData, 32'h0000_0001, "R11 readback");
  endtask

  task automatic testCpuBlock();
    wrCfg(32'h31);
    req = 4'b0001; dataDone = 1'b1;
    for (int i = 0; i < 4; i++) begin
      tick();
      chk(32'(grant), 32'h0, "R2 cpu disabled alone");
    end
    wrCfg(32'h30);
    chk(32'(grant), 32'h0, "R3 write takes effect next decision");
    chk(cfgRdData, 32'h30, "R3 disable bit cleared");
    tick();
    chk(32'(grant), 32'h1, "R3 cpu granted after enable");
    req = 4'b0000;
    tick();
    chk(32'(grant), 32'h0, "R1 grant single cycle");
  endtask

  task automatic testRoundRobin();
    req = 4'b1111;
    expectSeq('{4'b0010, 4'b0100, 4'b1000, 4'b0001}, "R7 rotate all");
    req = 4'b1010;
    expectSeq('{4'b0010, 4'b1000, 4'b0010}, "R7 rotate sparse");
    req = 4'b0000;
    tick();
  endtask

  task automatic testRptOther();
    wrCfg(32'h2030);
    req = 4'b1100; rptReq = 4'b0100;
    expectSeq('{4'b0100, 4'b0100, 4'b0100, 4'b1000, 4'b0100}, "R8 shared limit 3");
    req = 4'b0000; rptReq = 4'b0000;
    tick();
  endtask

  task automatic testRptPci();
    wrCfg(32'h2130);
    req = 4'b0001;
    tick();
    chk(32'(grant), 32'h1, "R9 prime cpu");
    req = 4'b0110; rptReq = 4'b0110;
    expectSeq('{4'b0010, 4'b0010, 4'b0100, 4'b0100, 4'b0100, 4'b0010}, "R9 pci limit 2 vs 3");
    req = 4'b0000; rptReq = 4'b0000;
    tick();
  endtask

  task automatic testNoRpt();
    wrCfg(32'h0030);
    req = 4'b0110; rptReq = 4'b0110;
    expectSeq('{4'b0100, 4'b0010, 4'b0100}, "R10 code zero ignores rptReq");
    req = 4'b0000; rptReq = 4'b0000;
    tick();
  endtask

  task automatic testDepth();
    wrCfg(32'h0010);
    dataDone = 1'b0; req = 4'b1000;
    expectSeq('{4'b1000, 4'b1000, 4'b0000, 4'b0000}, "R4 depth 2 stall");
    dataDone = 1'b1;
    tick();
    chk(32'(grant), 32'h0, "R6 freed slot not same decision");
    dataDone = 1'b0;
    tick();
    chk(32'(grant), 32'h8, "R6 freed slot used");
    tick();
    chk(32'(grant), 32'h0, "R4 full again");
    req = 4'b0000; dataDone = 1'b1;
    tick(); tick(); tick();
  endtask

  task automatic testResvDepth();
    wrCfg(32'h0060);
    chk(cfgRdData, 32'h60, "R11 reserved depth code readback");
    dataDone = 1'b0; req = 4'b1000;
    expectSeq('{4'b1000, 4'b0000, 4'b0000}, "R5 reserved code depth 1");
    req = 4'b0000; dataDone = 1'b1;
    tick(); tick();
  endtask

  task automatic testCpuSkip();
    wrCfg(32'h31);
    req = 4'b1111; dataDone = 1'b1;
    for (int i = 0; i < 6; i++) begin
      tick();
      chk(32'(grant[0]), 32'h0, "R2 cpu skipped in rotation");
      chk(32'(|grant), 32'h1, "R2 others still granted");
    end
    req = 4'b0000;
    tick();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; cpuDisStrap = 1'b1; cfgWrEn = 1'b0; cfgWrData = '0;
    req = '0; rptReq = '0; dataDone = 1'b0;
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    testReset();
    testRegs();
    testCpuBlock();
    testRoundRobin();
    testRptOther();
    testRptPci();
    testNoRpt();
    testDepth();
    testResvDepth();
    testCpuSkip();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule